// File: doc/BRIEF.md
# Configurable Pulse Counter with Compare Interrupt

This block counts pulses arriving on two raw input pins into a 32-bit signed register. A two-bit mode input chooses how the pins are read. In the first pair of modes, one pin counts up and the other counts down. In the second pair, one pin carries the pulses and the other gives the direction. Each pair has a single-edge variant and a double-rate variant. All pins pass through a synchroniser before any edge is detected. Each pin has its own polarity-invert bit.

A mask and a clear each come from two sources, a pin and a software bit, and the two are ORed. Mask freezes the count. Clear forces the count to zero. The host can load the count and a compare value, and can capture the count into a readable register. When the count first becomes equal to the compare value, the block raises a one-clock interrupt pulse. A separate enable gates only this pulse and never stops counting.

Top module: `pulse_cnt_top`

## Requirements
- R1: In mode 0 (`cfg_mode`=0), a rising edge on `in_a` adds 1 to the count and a rising edge on `in_b` subtracts 1. Falling edges are not counted.
- R2: In mode 1, both rising and falling edges of `in_a` add 1, and both edges of `in_b` subtract 1.
- R3: In modes 0 and 1, an up edge and a down edge detected in the same clock cancel, and the count does not change.
- R4: In mode 2, a rising edge of `in_a` adds 1 when the direction is 0 and subtracts 1 when it is 1. Edges on the direction input never count.
- R5: In mode 3, both edges of `in_a` are counted, and the direction sets the sign as in R4.
- R6: With `cfg_dir_sw`=1, the direction is taken from `sw_dir` and `in_b` is ignored. With `cfg_dir_sw`=0, the direction is taken from the synchronised `in_b`.
- R7: The effective mask is `hw_mask` OR `sw_mask`. While it is active, edges are discarded and the count holds.
- R8: The effective clear is `hw_clr` OR `sw_clr`. While it is active, the count reads 0, neither counting nor a host load takes effect, and counting resumes from 0 once it is released.
- R9: `cfg_inv` bit 0 inverts `in_a`, bit 1 inverts `in_b`, bit 2 inverts `hw_mask` and bit 3 inverts `hw_clr`. With all bits at 0, every input is active high.
- R10: `irq` is high for exactly one clock, the clock after the count first becomes equal to the compare value. It does not repeat while the two stay equal.
- R11: With `irq_en`=0, no interrupt is raised and counting continues unchanged.
- R12: `wr_cv` loads `wr_data` into the count and `wr_pv` loads it into the compare value. `snap` copies the count into `rd_cv`. After reset, the count, the compare value, `rd_cv` and `irq` are all 0.
- R13: The count wraps modulo 2^32 in two's complement, so 0xFFFFFFFF+1 gives 0 and 0x80000000-1 gives 0x7FFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | 1 | Up pulse or counted pulse pin |
| in_b | input | 1 | Down pulse or direction pin |
| hw_mask | input | 1 | Mask pin |
| hw_clr | input | 1 | Clear pin |
| cfg_mode | input | 2 | 0: up/down single edge, 1: up/down both edges, 2: pulse/dir single edge, 3: pulse/dir both edges |
| cfg_inv | input | 4 | Polarity invert bits: 0 in_a, 1 in_b, 2 hw_mask, 3 hw_clr |
| cfg_dir_sw | input | 1 | 1 selects sw_dir as the direction source |
| sw_dir | input | 1 | Software direction, 1 means down |
| sw_mask | input | 1 | Software mask bit |
| sw_clr | input | 1 | Software clear bit |
| irq_en | input | 1 | Interrupt enable |
| wr_cv | input | 1 | Load wr_data into the count |
| wr_pv | input | 1 | Load wr_data into the compare value |
| wr_data | input | 32 | Host write data |
| snap | input | 1 | Capture the count into rd_cv |
| rd_cv | output | 32 | Captured count |
| irq | output | 1 | One-clock equality interrupt |

## Verification
The bench drives isolated pulses on each pin in each of the four modes. This separates single-edge counting from double-rate counting and up steps from down steps. Coincident edges on both pins show that opposing steps cancel rather than one winning. Pins are toggled while mask or clear is active, with each source used alone, to show that both inputs of each OR act. Inverted-polarity runs show that inversion moves counting onto the opposite raw edge. Compare runs that pass through equality, stay there, and return show the difference between an edge-triggered pulse and a held level, with and without the enable.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [1:0] {
    MODE_UD_X1 = 2'd0,
    MODE_UD_X2 = 2'd1,
    MODE_PD_X1 = 2'd2,
    MODE_PD_X2 = 2'd3
  } pc_mode_e;

  localparam int INV_A    = 0;
  localparam int INV_B    = 1;
  localparam int INV_MASK = 2;
  localparam int INV_CLR  = 3;
  localparam int N_PINS   = 4;
endpackage

// File: rtl/pc_sync.sv
module pc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pc_step_dec.sv
module pc_step_dec
  import pc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     a_s,
  input  logic     b_s,
  input  pc_mode_e mode,
  input  logic     dir_sw_sel,
  input  logic     sw_dir,
  output logic     step_up,
  output logic     step_dn
);
  logic a_prev, b_prev;
  logic a_rise, a_fall, b_rise, b_fall, dir, pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_prev <= 1'b0;
      b_prev <= 1'b0;
    end else begin
      a_prev <= a_s;
      b_prev <= b_s;
    end
  end

  assign a_rise = a_s & ~a_prev;
  assign a_fall = ~a_s & a_prev;
  assign b_rise = b_s & ~b_prev;
  assign b_fall = ~b_s & b_prev;
  assign dir    = dir_sw_sel ? sw_dir : b_s;

  always_comb begin
    pulse   = 1'b0;
    step_up = 1'b0;
    step_dn = 1'b0;
    unique case (mode)
      MODE_UD_X1: begin
        step_up = a_rise;
        step_dn = b_rise;
      end
      MODE_UD_X2: begin
        step_up = a_rise | a_fall;
        step_dn = b_rise | b_fall;
      end
      MODE_PD_X1: begin
        pulse   = a_rise;
        step_up = pulse & ~dir;
        step_dn = pulse & dir;
      end
      default: begin
        pulse   = a_rise | a_fall;
        step_up = pulse & ~dir;
        step_dn = pulse & dir;
      end
    endcase
  end
endmodule

// File: rtl/pc_counter.sv
module pc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             mask,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             wr_cv,
  input  logic             wr_pv,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             snap,
  input  logic             irq_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] pv_q,
  output logic [CNT_W-1:0] rd_cv,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic eq, eq_prev;

  assign eq = (cnt_q == pv_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pv_q    <= '0;
      rd_cv   <= '0;
      eq_prev <= 1'b1;
      irq     <= 1'b0;
    end else begin
      if (clr)
        cnt_q <= '0;
      else if (wr_cv)
        cnt_q <= wr_data;
      else if (!mask && (step_up ^ step_dn))
        cnt_q <= step_up ? cnt_q + ONE : cnt_q - ONE;
      if (wr_pv) pv_q  <= wr_data;
      if (snap)  rd_cv <= cnt_q;
      eq_prev <= eq;
      irq     <= irq_en & eq & ~eq_prev;
    end
  end
endmodule

// File: rtl/pulse_cnt_top.sv
module pulse_cnt_top
  import pc_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             hw_mask,
  input  logic             hw_clr,
  input  logic [1:0]       cfg_mode,
  input  logic [3:0]       cfg_inv,
  input  logic             cfg_dir_sw,
  input  logic             sw_dir,
  input  logic             sw_mask,
  input  logic             sw_clr,
  input  logic             irq_en,
  input  logic             wr_cv,
  input  logic             wr_pv,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             snap,
  output logic [CNT_W-1:0] rd_cv,
  output logic             irq
);
  logic [N_PINS-1:0] raw_pins, pol_pins, sync_pins;
  logic              eff_mask, eff_clr, step_up, step_dn;
  logic [CNT_W-1:0]  cnt_q, pv_q;

  assign raw_pins[INV_A]    = in_a;
  assign raw_pins[INV_B]    = in_b;
  assign raw_pins[INV_MASK] = hw_mask;
  assign raw_pins[INV_CLR]  = hw_clr;
  assign pol_pins           = raw_pins ^ cfg_inv;

  pc_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pol_pins),
    .q   (sync_pins)
  );

  assign eff_mask = sync_pins[INV_MASK] | sw_mask;
  assign eff_clr  = sync_pins[INV_CLR]  | sw_clr;

  pc_step_dec u_dec (
    .clk        (clk),
    .rst        (rst),
    .a_s        (sync_pins[INV_A]),
    .b_s        (sync_pins[INV_B]),
    .mode       (pc_mode_e'(cfg_mode)),
    .dir_sw_sel (cfg_dir_sw),
    .sw_dir     (sw_dir),
    .step_up    (step_up),
    .step_dn    (step_dn)
  );

  pc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (eff_clr),
    .mask    (eff_mask),
    .step_up (step_up),
    .step_dn (step_dn),
    .wr_cv   (wr_cv),
    .wr_pv   (wr_pv),
    .wr_data (wr_data),
    .snap    (snap),
    .irq_en  (irq_en),
    .cnt_q   (cnt_q),
    .pv_q    (pv_q),
    .rd_cv   (rd_cv),
    .irq     (irq)
  );
endmodule

// File: rtl/pc_checker.sv
module pc_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] cnt,
  input logic [W-1:0] pv,
  input logic         eff_mask,
  input logic         eff_clr,
  input logic         wr_cv,
  input logic         irq_en,
  input logic         irq
);
  // R1 R13: without a host load, the count moves by at most one step, wraps, or clears
  p_single_step_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_cv)) |->
      (cnt == $past(cnt) || cnt == $past(cnt) + W'(1) ||
       cnt == $past(cnt) - W'(1) || cnt == '0));

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(eff_mask && !eff_clr && !wr_cv)) |-> cnt == $past(cnt));

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(eff_clr)) |-> cnt == '0);

  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_irq_equal_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && irq) |-> $past(cnt == pv));

  p_irq_gate_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(irq_en)) |-> !irq);
endmodule

bind pulse_cnt_top pc_checker #(.W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cnt      (cnt_q),
  .pv       (pv_q),
  .eff_mask (eff_mask),
  .eff_clr  (eff_clr),
  .wr_cv    (wr_cv),
  .irq_en   (irq_en),
  .irq      (irq)
);

// File: tb/sim_pulse_cnt_top.sv
`timescale 1ns/1ps
module sim_pulse_cnt_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_a = 0, in_b = 0, hw_mask = 0, hw_clr = 0;
  logic [1:0]  cfg_mode = 0;
  logic [3:0]  cfg_inv = 0;
  logic        cfg_dir_sw = 0, sw_dir = 0, sw_mask = 0, sw_clr = 0, irq_en = 0;
  logic        wr_cv = 0, wr_pv = 0, snap = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_cv;
  logic        irq;

  int n_tests = 0, n_fail = 0;
  int irq_n = 0, irq_run = 0, irq_max = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pulse_cnt_top u0 (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .hw_mask(hw_mask), .hw_clr(hw_clr),
    .cfg_mode(cfg_mode), .cfg_inv(cfg_inv), .cfg_dir_sw(cfg_dir_sw), .sw_dir(sw_dir),
    .sw_mask(sw_mask), .sw_clr(sw_clr), .irq_en(irq_en), .wr_cv(wr_cv), .wr_pv(wr_pv),
    .wr_data(wr_data), .snap(snap), .rd_cv(rd_cv), .irq(irq)
  );

  always @(posedge clk) begin
    if (irq) begin
      irq_n++;
      irq_run++;
      if (irq_run > irq_max) irq_max = irq_run;
    end else begin
      irq_run = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_a(input logic v);
    @(negedge clk) in_a = v;
    idle(4);
  endtask

  task automatic set_b(input logic v);
    @(negedge clk) in_b = v;
    idle(4);
  endtask

  task automatic pulse_a(input int n);
    for (int i = 0; i < n; i++) begin set_a(1); set_a(0); end
  endtask

  task automatic pulse_b(input int n);
    for (int i = 0; i < n; i++) begin set_b(1); set_b(0); end
  endtask

  task automatic load_cv(input logic [31:0] v);
    @(negedge clk) begin wr_data = v; wr_cv = 1; end
    @(negedge clk) wr_cv = 0;
    idle(1);
  endtask

  task automatic load_pv(input logic [31:0] v);
    @(negedge clk) begin wr_data = v; wr_pv = 1; end
    @(negedge clk) wr_pv = 0;
    idle(1);
  endtask

  task automatic read_cv(output logic [31:0] v);
    @(negedge clk) snap = 1;
    @(negedge clk) snap = 0;
    v = rd_cv;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R12 reset irq", {31'd0, irq}, 32'd0);
    read_cv(v);
    chk("R12 reset count", v, 32'd0);
  endtask

  task automatic t_updown_x1();
    logic [31:0] v;
    cfg_mode = 2'd0;
    load_cv(0);
    pulse_a(3);
    pulse_b(1);
    read_cv(v);
    chk("R1 up/down single edge", v, 32'd2);
  endtask

  task automatic t_updown_x2();
    logic [31:0] v;
    cfg_mode = 2'd1;
    load_cv(10);
    pulse_a(2);
    read_cv(v);
    chk("R2 both edges up", v, 32'd14);
    pulse_b(1);
    read_cv(v);
    chk("R2 both edges down", v, 32'd12);
  endtask

  task automatic t_cancel();
    logic [31:0] v;
    cfg_mode = 2'd0;
    load_cv(20);
    @(negedge clk) begin in_a = 1; in_b = 1; end
    idle(4);
    read_cv(v);
    chk("R3 coincident rising cancel", v, 32'd20);
    @(negedge clk) begin in_a = 0; in_b = 0; end
    idle(4);
    cfg_mode = 2'd1;
    @(negedge clk) begin in_a = 1; in_b = 1; end
    idle(4);
    @(negedge clk) begin in_a = 0; in_b = 0; end
    idle(4);
    read_cv(v);
    chk("R3 coincident both-edge cancel", v, 32'd20);
    pulse_a(1);
    read_cv(v);
    chk("R2 lone pulse after cancel", v, 32'd22);
  endtask

  task automatic t_pdir();
    logic [31:0] v;
    cfg_mode = 2'd2;
    load_cv(0);
    pulse_a(3);
    set_b(1);
    pulse_a(1);
    read_cv(v);
    chk("R4 pulse/dir single edge", v, 32'd2);
    cfg_mode = 2'd3;
    pulse_a(2);
    read_cv(v);
    chk("R5 pulse/dir both edges down", v, 32'hFFFF_FFFE);
    set_b(0);
    pulse_a(1);
    read_cv(v);
    chk("R5 pulse/dir both edges up", v, 32'd0);
  endtask

  task automatic t_dirsel();
    logic [31:0] v;
    cfg_mode = 2'd2;
    cfg_dir_sw = 1;
    sw_dir = 1;
    load_cv(0);
    pulse_a(1);
    read_cv(v);
    chk("R6 software direction down", v, 32'hFFFF_FFFF);
    sw_dir = 0;
    set_b(1);
    pulse_a(1);
    read_cv(v);
    chk("R6 in_b ignored", v, 32'd0);
    cfg_dir_sw = 0;
    pulse_a(1);
    read_cv(v);
    chk("R6 external direction", v, 32'hFFFF_FFFF);
    set_b(0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    cfg_mode = 2'd0;
    load_cv(5);
    @(negedge clk) hw_mask = 1;
    idle(4);
    pulse_a(2);
    read_cv(v);
    chk("R7 hw mask holds", v, 32'd5);
    @(negedge clk) begin hw_mask = 0; sw_mask = 1; end
    idle(4);
    pulse_b(1);
    read_cv(v);
    chk("R7 sw mask holds", v, 32'd5);
    sw_mask = 0;
    pulse_a(1);
    read_cv(v);
    chk("R7 unmasked counts", v, 32'd6);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    cfg_mode = 2'd0;
    load_cv(50);
    @(negedge clk) hw_clr = 1;
    idle(4);
    read_cv(v);
    chk("R8 hw clear zero", v, 32'd0);
    pulse_a(1);
    load_cv(7);
    read_cv(v);
    chk("R8 clear overrides count and load", v, 32'd0);
    @(negedge clk) hw_clr = 0;
    idle(4);
    pulse_a(1);
    read_cv(v);
    chk("R8 resume from zero", v, 32'd1);
    @(negedge clk) sw_clr = 1;
    idle(2);
    read_cv(v);
    chk("R8 sw clear zero", v, 32'd0);
    sw_clr = 0;
    pulse_a(1);
    read_cv(v);
    chk("R8 resume after sw clear", v, 32'd1);
  endtask

  task automatic t_invert();
    logic [31:0] v;
    cfg_mode = 2'd0;
    @(negedge clk) cfg_inv = 4'b0001;
    idle(4);
    load_cv(0);
    set_a(1);
    read_cv(v);
    chk("R9 inverted raw rise not counted", v, 32'd0);
    set_a(0);
    read_cv(v);
    chk("R9 inverted raw fall counted", v, 32'd1);
    @(negedge clk) cfg_inv = 4'b0101;
    idle(4);
    set_a(1);
    set_a(0);
    read_cv(v);
    chk("R9 inverted mask active when low", v, 32'd1);
    @(negedge clk) cfg_inv = 4'b0000;
    idle(4);
    pulse_a(1);
    read_cv(v);
    chk("R9 default polarity restored", v, 32'd2);
  endtask

  task automatic t_irq();
    cfg_mode = 2'd0;
    irq_en = 0;
    load_pv(3);
    load_cv(0);
    idle(2);
    @(negedge clk) begin irq_en = 1; irq_n = 0; irq_max = 0; end
    pulse_a(3);
    chk("R10 irq on reaching compare", irq_n, 32'd1);
    idle(10);
    chk("R10 no repeat while equal", irq_n, 32'd1);
    pulse_a(1);
    pulse_b(1);
    chk("R10 irq on re-entry", irq_n, 32'd2);
    chk("R10 irq one clock wide", irq_max, 32'd1);
  endtask

  task automatic t_irq_off();
    logic [31:0] v;
    @(negedge clk) irq_en = 0;
    load_cv(0);
    load_pv(2);
    @(negedge clk) irq_n = 0;
    pulse_a(2);
    chk("R11 disabled irq silent", irq_n, 32'd0);
    read_cv(v);
    chk("R11 count continues", v, 32'd2);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    cfg_mode = 2'd0;
    load_cv(32'hFFFF_FFFF);
    pulse_a(1);
    read_cv(v);
    chk("R13 wrap up", v, 32'd0);
    load_cv(32'h8000_0000);
    pulse_b(1);
    read_cv(v);
    chk("R13 wrap down", v, 32'h7FFF_FFFF);
    load_cv(32'h1234_5678);
    read_cv(v);
    chk("R12 host load", v, 32'h1234_5678);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    idle(2);
    t_reset();
    t_updown_x1();
    t_updown_x2();
    t_cancel();
    t_pdir();
    t_dirsel();
    t_mask();
    t_clear();
    t_invert();
    t_irq();
    t_irq_off();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule